// File: doc/BRIEF.md
# Branch History Table Predictor

This block predicts the direction and next fetch address of branches for an instruction fetch stage. It keeps a small fully associative table; each entry holds a branch address used as the tag, the target the branch last went to, and a two-bit hysteresis counter. Every lookup compares the fetch address with all valid tags at once. The answer is registered and appears one cycle later. It gives a hit flag, a taken or not-taken decision and the address fetch should use next.

When a branch resolves, the outcome, its actual target and the next address fetch had used for it come back to the block. A branch already in the table gets its counter stepped and its target refreshed. A branch that is not in the table is placed in an empty slot. Once every slot is in use, a round-robin pointer chooses the entry to overwrite. The actual next address is compared with the address that was fetched. If they differ, a registered mispredict pulse goes out with the address fetch must restart from.

A branch that is not in the table falls back to a fixed rule based on the target supplied by the decoder. A backward target is predicted taken and a forward target is predicted not taken.

Top module: `bhtp_top`

## Requirements
- R1: After a synchronous active-high reset, every table entry is invalid and `pred_valid` and `mis_flush` are low; a lookup right after reset reports a miss.
- R2: A lookup asserted with `fch_valid` in one cycle produces its result with `pred_valid` high in the next cycle; without `fch_valid` the following cycle has `pred_valid` low.
- R3: On a miss, `pred_hit` is 0 and the prediction is taken exactly when `fch_target` is less than or equal to `fch_pc`; the next address is then `fch_target`, and otherwise `fch_pc + 1`.
- R4: On a hit, the prediction is bit 0 of the entry's counter. The next address is the stored target when that bit is 1 and `fch_pc + 1` when it is 0, even if the static rule would decide otherwise.
- R5: Counter codes are 2'b00 strong not-taken, 2'b10 weak not-taken, 2'b01 weak taken and 2'b11 strong taken. A correct outcome moves the counter to the strong state of its direction. A wrong outcome moves a strong state to the weak state of the same direction, and a weak state to the strong state of the opposite direction. A hit update also stores `res_target` as the entry's target.
- R6: A resolved branch that misses allocates an entry tagged with `res_pc`, holding `res_target` and the weak state of the resolved outcome.
- R7: A prediction changes direction only after two wrong outcomes in a row, so a branch taken repeatedly and then not taken once is still predicted taken.
- R8: Allocation fills the lowest-numbered invalid entry first, and a branch address is never held by more than one entry.
- R9: With every entry valid, allocation overwrites entries in round-robin order starting at entry 0 after reset and wrapping after the last one.
- R10: One cycle after a resolution, `mis_flush` is high exactly when the actual next address differs from `res_pred_next`. The actual next address is `res_target` if taken and `res_pc + 1` if not, and `mis_pc` then carries it.
- R11: When a lookup and a resolution address the same branch in one cycle, the lookup reports the table contents from before that update, and the update still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fch_valid | input | 1 | Lookup request |
| fch_pc | input | ADDR_W | Address of the branch being fetched |
| fch_target | input | ADDR_W | Decoded target, used by the static rule on a miss |
| pred_valid | output | 1 | Lookup result valid (one cycle after request) |
| pred_hit | output | 1 | Branch found in the table |
| pred_taken | output | 1 | Predicted direction |
| pred_next | output | ADDR_W | Predicted next fetch address |
| res_valid | input | 1 | Resolution of a branch |
| res_pc | input | ADDR_W | Address of the resolved branch |
| res_taken | input | 1 | Actual outcome |
| res_target | input | ADDR_W | Actual branch target |
| res_pred_next | input | ADDR_W | Next address fetch used for this branch |
| mis_flush | output | 1 | Discard fetched work and restart |
| mis_pc | output | ADDR_W | Restart address |

## Verification
Directed sequences first exercise the static rule with backward, forward and equal targets on an empty table. They then run a single loop branch through taken and not-taken streaks, which separates the two-step hysteresis from a one-bit scheme and shows that a hit overrides the static rule. A separate pass fills every slot and then adds three more branches. This separates round-robin eviction that starts at entry 0 from an allocator that reuses a fixed slot or skips free slots. The remaining cycles draw random lookups and resolutions from a pool of more branches than the table holds, with lookups and updates often colliding on one address. Against the bench's model, this exposes ordering errors between a lookup and an update in the same cycle, as well as wrong mispredict decisions.

// File: rtl/bhtp_pkg.sv
package bhtp_pkg;

  // Two-bit hysteresis counter; bit 0 is the predicted direction.
  typedef enum logic [1:0] {
    CTR_SNT = 2'b00,
    CTR_WT  = 2'b01,
    CTR_WNT = 2'b10,
    CTR_ST  = 2'b11
  } ctr_e;

  function automatic ctr_e ctr_step(ctr_e cur, logic taken);
    ctr_e nxt;
    unique case (cur)
      CTR_ST:  nxt = taken ? CTR_ST : CTR_WT;
      CTR_WT:  nxt = taken ? CTR_ST : CTR_SNT;
      CTR_WNT: nxt = taken ? CTR_ST : CTR_SNT;
      default: nxt = taken ? CTR_WNT : CTR_SNT;
    endcase
    return nxt;
  endfunction

  function automatic ctr_e ctr_seed(logic taken);
    return taken ? CTR_WT : CTR_WNT;
  endfunction

  function automatic logic ctr_taken(ctr_e cur);
    return cur[0];
  endfunction

endpackage

// File: rtl/bhtp_match.sv
module bhtp_match #(
  parameter int ENTRIES = 64,
  parameter int ADDR_W  = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [ENTRIES-1:0]             ent_valid,
  input  logic [ENTRIES-1:0][ADDR_W-1:0] ent_tag,
  input  logic [ADDR_W-1:0]              key,
  output logic                           hit,
  output logic [IDX_W-1:0]               idx
);

  logic [ENTRIES-1:0] match;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_cmp
      assign match[g] = ent_valid[g] && (ent_tag[g] == key);
    end
  endgenerate

  always_comb begin
    idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) idx = idx | IDX_W'(i);
    end
  end

  assign hit = |match;

  // R8: allocation never creates a second entry for one address
  p_single_match_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match));

endmodule

// File: rtl/bhtp_victim.sv
module bhtp_victim #(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] ent_valid,
  input  logic               alloc,
  output logic [IDX_W-1:0]   idx
);

  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;
  logic             full;

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!ent_valid[i]) free_idx = IDX_W'(i);
    end
  end

  assign full = &ent_valid;
  assign idx  = full ? rr_q : free_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_q <= '0;
    end else if (alloc && full) begin
      rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  // R8: a free slot is always chosen while one exists
  p_fill_free_r8: assert property (@(posedge clk) disable iff (rst)
    (alloc && !full) |-> !ent_valid[idx]);

endmodule

// File: rtl/bhtp_top.sv
module bhtp_top
  import bhtp_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int ADDR_W  = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fch_valid,
  input  logic [ADDR_W-1:0] fch_pc,
  input  logic [ADDR_W-1:0] fch_target,
  output logic              pred_valid,
  output logic              pred_hit,
  output logic              pred_taken,
  output logic [ADDR_W-1:0] pred_next,
  input  logic              res_valid,
  input  logic [ADDR_W-1:0] res_pc,
  input  logic              res_taken,
  input  logic [ADDR_W-1:0] res_target,
  input  logic [ADDR_W-1:0] res_pred_next,
  output logic              mis_flush,
  output logic [ADDR_W-1:0] mis_pc
);

  // Table storage: valid bits are reset, payload is not.
  logic [ENTRIES-1:0]             valid_q;
  logic [ENTRIES-1:0][ADDR_W-1:0] tag_q;
  logic [ADDR_W-1:0]              tgt_q [ENTRIES];
  ctr_e                           ctr_q [ENTRIES];

  logic             lk_hit, up_hit;
  logic [IDX_W-1:0] lk_idx, up_idx, vic_idx;
  logic             alloc;

  bhtp_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_lk_match (
    .clk(clk), .rst(rst), .ent_valid(valid_q), .ent_tag(tag_q),
    .key(fch_pc), .hit(lk_hit), .idx(lk_idx));

  bhtp_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_up_match (
    .clk(clk), .rst(rst), .ent_valid(valid_q), .ent_tag(tag_q),
    .key(res_pc), .hit(up_hit), .idx(up_idx));

  assign alloc = res_valid && !up_hit;

  bhtp_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk(clk), .rst(rst), .ent_valid(valid_q), .alloc(alloc), .idx(vic_idx));

  // Lookup: hit uses the counter, miss uses the backward/forward rule.
  logic              lk_taken;
  logic [ADDR_W-1:0] lk_next, lk_seq;

  assign lk_seq = fch_pc + 1'b1;

  always_comb begin
    if (lk_hit) begin
      lk_taken = ctr_taken(ctr_q[lk_idx]);
      lk_next  = lk_taken ? tgt_q[lk_idx] : lk_seq;
    end else begin
      lk_taken = (fch_target <= fch_pc);
      lk_next  = lk_taken ? fch_target : lk_seq;
    end
  end

  // Resolution: actual next address and write index.
  logic [ADDR_W-1:0] res_actual;
  logic [IDX_W-1:0]  wr_idx;
  ctr_e              wr_ctr;

  assign res_actual = res_taken ? res_target : res_pc + 1'b1;
  assign wr_idx     = up_hit ? up_idx : vic_idx;
  assign wr_ctr     = up_hit ? ctr_step(ctr_q[up_idx], res_taken) : ctr_seed(res_taken);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q    <= '0;
      pred_valid <= 1'b0;
      pred_hit   <= 1'b0;
      pred_taken <= 1'b0;
      pred_next  <= '0;
      mis_flush  <= 1'b0;
      mis_pc     <= '0;
    end else begin
      pred_valid <= fch_valid;
      if (fch_valid) begin
        pred_hit   <= lk_hit;
        pred_taken <= lk_taken;
        pred_next  <= lk_next;
      end
      mis_flush <= res_valid && (res_actual != res_pred_next);
      if (res_valid) begin
        mis_pc <= res_actual;
        if (alloc) valid_q[vic_idx] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (res_valid) begin
      tag_q[wr_idx] <= res_pc;
      tgt_q[wr_idx] <= res_target;
      ctr_q[wr_idx] <= wr_ctr;
    end
  end

  // R2: result follows a request by exactly one cycle
  p_pred_follows_r2: assert property (@(posedge clk) disable iff (rst)
    fch_valid |=> pred_valid);
  p_pred_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !fch_valid |=> !pred_valid);

  // R3: a taken miss never points forward
  p_miss_backward_r3: assert property (@(posedge clk) disable iff (rst)
    (pred_valid && !pred_hit && pred_taken) |-> (pred_next <= $past(fch_pc)));

  // R10: a flush always stems from a resolution one cycle earlier
  p_flush_source_r10: assert property (@(posedge clk) disable iff (rst)
    mis_flush |-> $past(res_valid));

  // R6: a freshly allocated entry holds the weak state of its outcome
  p_seed_weak_r6: assert property (@(posedge clk) disable iff (rst)
    alloc |=> (ctr_q[$past(vic_idx)] == ($past(res_taken) ? CTR_WT : CTR_WNT)));

  genvar e;
  generate
    for (e = 0; e < ENTRIES; e++) begin : g_ctr_chk
      // R5: one wrong outcome softens a strong taken entry without flipping it
      p_strong_soft_r5: assert property (@(posedge clk) disable iff (rst)
        (res_valid && up_hit && (up_idx == IDX_W'(e)) && (ctr_q[e] == CTR_ST) && !res_taken)
        |=> (ctr_q[e] == CTR_WT));
    end
  endgenerate

endmodule

// File: tb/bhtp_top_tb_top.sv
`timescale 1ns/1ps
module bhtp_top_tb_top;

  localparam int N  = 64;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          fch_valid = 1'b0;
  logic [AW-1:0] fch_pc = '0, fch_target = '0;
  logic          pred_valid, pred_hit, pred_taken;
  logic [AW-1:0] pred_next;
  logic          res_valid = 1'b0, res_taken = 1'b0;
  logic [AW-1:0] res_pc = '0, res_target = '0, res_pred_next = '0;
  logic          mis_flush;
  logic [AW-1:0] mis_pc;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  bhtp_top #(.ENTRIES(N), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst),
    .fch_valid(fch_valid), .fch_pc(fch_pc), .fch_target(fch_target),
    .pred_valid(pred_valid), .pred_hit(pred_hit), .pred_taken(pred_taken),
    .pred_next(pred_next),
    .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
    .res_target(res_target), .res_pred_next(res_pred_next),
    .mis_flush(mis_flush), .mis_pc(mis_pc));

  // Reference model of the table
  logic          m_v   [N];
  logic [AW-1:0] m_pc  [N];
  logic [AW-1:0] m_tg  [N];
  logic [1:0]    m_ct  [N];
  int            m_rr;

  function automatic int m_find(logic [AW-1:0] pc);
    for (int i = 0; i < N; i++) if (m_v[i] && m_pc[i] == pc) return i;
    return -1;
  endfunction

  function automatic logic [1:0] m_next(logic [1:0] c, logic t);
    if (t) return (c == 2'b00) ? 2'b10 : 2'b11;
    return (c == 2'b11) ? 2'b01 : 2'b00;
  endfunction

  task automatic m_clear();
    for (int i = 0; i < N; i++) m_v[i] = 1'b0;
    m_rr = 0;
  endtask

  task automatic m_lookup(input logic [AW-1:0] pc, tg,
                          output logic h, output logic t, output logic [AW-1:0] nx);
    int k;
    k = m_find(pc);
    h = (k >= 0);
    if (h) begin
      t  = m_ct[k][0];
      nx = t ? m_tg[k] : AW'(pc + 1);
    end else begin
      t  = (tg <= pc);
      nx = t ? tg : AW'(pc + 1);
    end
  endtask

  task automatic m_update(input logic [AW-1:0] pc, input logic t, input logic [AW-1:0] tg);
    int k;
    k = m_find(pc);
    if (k >= 0) begin
      m_ct[k] = m_next(m_ct[k], t);
      m_tg[k] = tg;
    end else begin
      k = -1;
      for (int i = N - 1; i >= 0; i--) if (!m_v[i]) k = i;
      if (k < 0) begin
        k = m_rr;
        m_rr = (m_rr + 1) % N;
      end
      m_v[k]  = 1'b1;
      m_pc[k] = pc;
      m_tg[k] = tg;
      m_ct[k] = t ? 2'b01 : 2'b10;
    end
  endtask

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    fch_valid = 1'b0;
    res_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_clear();
  endtask

  // One cycle: drive at negedge, model, check at the next negedge.
  task automatic step(input logic lv, input logic [AW-1:0] lpc, ltg,
                      input logic rv, input logic [AW-1:0] rpc, input logic rt,
                      input logic [AW-1:0] rtg, rpn, input string tag);
    logic          eh, et, ef;
    logic [AW-1:0] en, ea;
    fch_valid = lv; fch_pc = lpc; fch_target = ltg;
    res_valid = rv; res_pc = rpc; res_taken = rt; res_target = rtg; res_pred_next = rpn;
    eh = 1'b0; et = 1'b0; en = '0;
    if (lv) m_lookup(lpc, ltg, eh, et, en);
    ea = rt ? rtg : AW'(rpc + 1);
    ef = rv && (ea != rpn);
    if (rv) m_update(rpc, rt, rtg);
    @(negedge clk);
    chk(pred_valid == lv, tag, "pred_valid", AW'(pred_valid), AW'(lv));
    if (lv) begin
      chk(pred_hit == eh, tag, "pred_hit", AW'(pred_hit), AW'(eh));
      chk(pred_taken == et, tag, "pred_taken", AW'(pred_taken), AW'(et));
      chk(pred_next == en, tag, "pred_next", pred_next, en);
    end
    chk(mis_flush == ef, tag, "mis_flush", AW'(mis_flush), AW'(ef));
    if (ef) chk(mis_pc == ea, tag, "mis_pc", mis_pc, ea);
  endtask

  task automatic look(input logic [AW-1:0] pc, tg, input string tag);
    step(1'b1, pc, tg, 1'b0, '0, 1'b0, '0, '0, tag);
  endtask

  task automatic resolve(input logic [AW-1:0] pc, input logic t,
                         input logic [AW-1:0] tg, pn, input string tag);
    step(1'b0, '0, '0, 1'b1, pc, t, tg, pn, tag);
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic h, t;
    logic [AW-1:0] nx, pc, tg;
    void'($urandom(32'd20240611));
    m_clear();
    do_reset();

    // R1: idle after reset, empty table
    chk(pred_valid == 1'b0, "R1", "pred_valid after reset", AW'(pred_valid), '0);
    chk(mis_flush == 1'b0, "R1", "mis_flush after reset", AW'(mis_flush), '0);
    look(16'd100, 16'd40, "R1");

    // R3: static rule on misses, R2 request/idle timing
    look(16'd100, 16'd200, "R3");
    look(16'd100, 16'd100, "R3");
    step(1'b0, '0, '0, 1'b0, '0, 1'b0, '0, '0, "R2");

    // R6 and R10: allocate a loop branch after a wrong static guess
    resolve(16'd100, 1'b1, 16'd40, 16'd101, "R10");
    look(16'd100, 16'd40, "R6");
    // R7: taken streak, then a single exit
    resolve(16'd100, 1'b1, 16'd40, 16'd40, "R5");
    resolve(16'd100, 1'b1, 16'd40, 16'd40, "R5");
    resolve(16'd100, 1'b0, 16'd40, 16'd40, "R10");
    look(16'd100, 16'd40, "R7");
    resolve(16'd100, 1'b1, 16'd40, 16'd40, "R5");
    resolve(16'd100, 1'b0, 16'd40, 16'd40, "R7");
    resolve(16'd100, 1'b0, 16'd40, 16'd40, "R7");
    look(16'd100, 16'd40, "R7");

    // R11: lookup and update on the same branch in one cycle
    step(1'b1, 16'd100, 16'd40, 1'b1, 16'd100, 1'b1, 16'd40, 16'd101, "R11");
    step(1'b1, 16'd100, 16'd40, 1'b1, 16'd100, 1'b1, 16'd40, 16'd101, "R11");
    look(16'd100, 16'd40, "R11");

    // R4: stored forward taken branch overrides the static rule
    resolve(16'd300, 1'b1, 16'd400, 16'd301, "R6");
    look(16'd300, 16'd400, "R4");

    // R8 / R9: fill all slots, then evict in round-robin order
    do_reset();
    for (int k = 0; k < N; k++) resolve(AW'(16'h1000 + k), 1'b0, 16'h0800, 16'(16'h1001 + k), "R8");
    look(16'h1000, 16'h0800, "R8");
    look(AW'(16'h1000 + N - 1), 16'h0800, "R8");
    for (int k = 0; k < 3; k++) resolve(AW'(16'h2000 + k), 1'b1, 16'h3000, 16'h3000, "R9");
    for (int k = 0; k < 4; k++) look(AW'(16'h1000 + k), 16'h0800, "R9");
    for (int k = 0; k < 3; k++) look(AW'(16'h2000 + k), 16'h3000, "R9");
    resolve(16'h2100, 1'b0, 16'h3000, 16'h2101, "R9");
    look(16'h1003, 16'h0800, "R9");

    // Random traffic over more branches than the table holds
    do_reset();
    for (int n = 0; n < 4000; n++) begin
      logic lv, rv, rt;
      logic [AW-1:0] lpc, ltg, rpc, rtg, rpn;
      int a, b;
      a = $urandom_range(0, 95);
      b = ($urandom_range(0, 3) == 0) ? a : $urandom_range(0, 95);
      lpc = AW'(16'h0200 + 4 * a);
      ltg = (a % 2) ? AW'(lpc - 20) : AW'(lpc + 36);
      rpc = AW'(16'h0200 + 4 * b);
      rtg = (b % 2) ? AW'(rpc - 20) : AW'(rpc + 36);
      lv = ($urandom_range(0, 3) != 0);
      rv = ($urandom_range(0, 2) != 0);
      rt = ($urandom_range(0, 99) < ((b % 2) ? 80 : 30));
      m_lookup(rpc, rtg, h, t, nx);
      rpn = ($urandom_range(0, 9) == 0) ? AW'($urandom) : nx;
      step(lv, lpc, ltg, rv, rpc, rt, rtg, rpn, "R5");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule